// File: doc/BRIEF.md
# Die-to-die flit packetizer with CRC-16

This block sits on the transmit path of a die-to-die adapter. Each cycle it can take one 64-byte protocol payload and wrap it into a 68-byte flit. The flit is made of a 2-byte header, the payload, and a 2-byte CRC. The header packs a protocol identifier, a credit-return flag, a link-level ack/nak command and an 8-bit sequence number. The CRC always covers a 128-byte window: the header and payload are followed by zero bytes up to the end of that window. A single register stage drives the wide byte-parallel output under a valid/ready handshake.

When the output stage is free and the protocol side offers no payload, the block emits an idle flit. An idle flit has an all-zero payload and an idle protocol identifier. It still carries the credit flag, the ack/nak command and the sequence number. The flit size is settled by link negotiation before traffic starts. Only the 68-byte size is built. While the configuration input asks for the 256-byte size, the block emits nothing and accepts nothing.

Top module: `flit_pack`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, out_valid is 0. With cfg_flit256 = 0 and the output stage empty, in_ready is 1.
- R2: Header bits of the output flit, out_flit[543:528], are packed as follows from the most significant bit down: protocol ID [15:13], credit [12], ack/nak command [11:10], sequence [9:2], and reserved [1:0]. The reserved bits are 0. The fields are taken from the inputs present in the cycle the flit was loaded.
- R3: A payload accepted with in_valid = 1 and in_ready = 1 appears unchanged in out_flit[527:16] in the next cycle. Payload byte 0 is in_payload[511:504] and is sent immediately after the header.
- R4: out_flit[15:0] is a CRC-16 with generator polynomial 0x8BB7 (parameter), initial value 0 and no final inversion. It is computed most-significant-bit first over 128 bytes: the 2 header bytes, then the 64 payload bytes, then 62 zero bytes.
- R5: When the stage loads and in_valid = 0, the flit is idle. Its payload is all zeros and its protocol ID is IDLE_PID (default 0). Its credit, ack/nak and sequence fields still come from the inputs, and its CRC follows R4.
- R6: While out_valid = 1 and out_ready = 0, in_ready is 0 and out_flit holds its value in the next cycle.
- R7: With out_ready held at 1 and cfg_flit256 = 0, a new flit is loaded every cycle. A payload is therefore accepted every cycle it is offered.
- R8: While cfg_flit256 = 1, in_ready is 0, and out_valid is 0 from the following cycle on.
- R9: Every error pattern of one, two or three flipped bits in the header and payload changes the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_flit256 | input | 1 | Negotiated flit size is 256 bytes (unsupported, halts output) |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Output stage loads this cycle |
| in_payload | input | 512 | 64-byte payload, byte 0 in the top bits |
| in_pid | input | 3 | Protocol identifier |
| in_credit | input | 1 | Credit-return flag |
| in_ack_cmd | input | 2 | Ack/nak command |
| in_seq | input | 8 | Ack/nak sequence number |
| out_valid | output | 1 | Flit present on out_flit |
| out_ready | input | 1 | Downstream takes the flit |
| out_flit | output | 544 | Flit: header top, payload, CRC bottom |

## Verification
A corrupted byte in the CRC chain, a mispositioned header field or a swapped payload byte shows up on out_flit in the cycle right after the flit is loaded. The bench compares the whole flit against its own bit-serial model on every clock, so such a fault is reported at once. A wrong load or flush condition shows up in the same cycle as a mismatch on in_ready, or one cycle later on out_valid. This can take the form of a stage that drops a held flit under backpressure or keeps emitting while the 256-byte size is selected. The flip-detection property is checked both on the model and on the design's CRC output for flipped payloads.

// File: rtl/flit_pkg.sv
`timescale 1ns/1ps
package flit_pkg;

   typedef struct packed {
      logic [2:0] pid;
      logic       credit;
      logic [1:0] ack_cmd;
      logic [7:0] seq;
      logic [1:0] rsvd;
   } flit_hdr_t;

   localparam int HDR_BYTES = 2;
   localparam int CRC_BYTES = 2;
   localparam int CRC_W     = 16;

   // one byte folded into the running remainder, most significant bit first
   function automatic logic [CRC_W-1:0] crc_byte_step(input logic [CRC_W-1:0] rem,
                                                      input logic [7:0]       data,
                                                      input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] r;
      r = rem ^ {data, {(CRC_W-8){1'b0}}};
      for (int k = 0; k < 8; k++) begin
         if (r[CRC_W-1]) r = {r[CRC_W-2:0], 1'b0} ^ poly;
         else            r = {r[CRC_W-2:0], 1'b0};
      end
      return r;
   endfunction

endpackage

// File: rtl/flit_hdr_pack.sv
`timescale 1ns/1ps
module flit_hdr_pack #(
   parameter logic [2:0] IDLE_PID = 3'd0
) (
   input  logic        idle,
   input  logic [2:0]  pid,
   input  logic        credit,
   input  logic [1:0]  ack_cmd,
   input  logic [7:0]  seq,
   output logic [15:0] hdr
);
   flit_pkg::flit_hdr_t h;

   always_comb begin
      h.pid     = idle ? IDLE_PID : pid;
      h.credit  = credit;
      h.ack_cmd = ack_cmd;
      h.seq     = seq;
      h.rsvd    = '0;
   end

   assign hdr = h;
endmodule

// File: rtl/flit_crc_gen.sv
`timescale 1ns/1ps
module flit_crc_gen #(
   parameter int          MSG_BYTES    = 66,
   parameter int          WINDOW_BYTES = 128,
   parameter logic [15:0] POLY         = 16'h8BB7
) (
   input  logic [MSG_BYTES*8-1:0] msg,
   output logic [15:0]            crc
);
   logic [15:0] chain [0:WINDOW_BYTES];

   assign chain[0] = '0;

   for (genvar i = 0; i < WINDOW_BYTES; i++) begin : g_byte
      logic [7:0] b;
      if (i < MSG_BYTES) begin : g_msg
         assign b = msg[8*(MSG_BYTES-1-i) +: 8];
      end else begin : g_pad
         assign b = '0;
      end
      assign chain[i+1] = flit_pkg::crc_byte_step(chain[i], b, POLY);
   end

   assign crc = chain[WINDOW_BYTES];
endmodule

// File: rtl/flit_out_stage.sv
`timescale 1ns/1ps
module flit_out_stage #(
   parameter int W = 544
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         vld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
         q   <= '0;
      end else if (flush) begin
         vld <= 1'b0;
      end else if (load) begin
         vld <= 1'b1;
         q   <= d;
      end
   end
endmodule

// File: rtl/flit_pack.sv
`timescale 1ns/1ps
module flit_pack #(
   parameter int          PAYLOAD_BYTES = 64,
   parameter int          WINDOW_BYTES  = 128,
   parameter logic [15:0] CRC_POLY      = 16'h8BB7,
   parameter logic [2:0]  IDLE_PID      = 3'd0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cfg_flit256,
   input  logic                                in_valid,
   output logic                                in_ready,
   input  logic [PAYLOAD_BYTES*8-1:0]          in_payload,
   input  logic [2:0]                          in_pid,
   input  logic                                in_credit,
   input  logic [1:0]                          in_ack_cmd,
   input  logic [7:0]                          in_seq,
   output logic                                out_valid,
   input  logic                                out_ready,
   output logic [(PAYLOAD_BYTES+4)*8-1:0]      out_flit
);
   localparam int MSG_BYTES  = flit_pkg::HDR_BYTES + PAYLOAD_BYTES;
   localparam int FLIT_BYTES = MSG_BYTES + flit_pkg::CRC_BYTES;
   localparam int FLIT_BITS  = FLIT_BYTES * 8;
   localparam int PL_BITS    = PAYLOAD_BYTES * 8;

   initial begin : p_params
      assert (WINDOW_BYTES >= MSG_BYTES)
         else $error("CRC window smaller than header plus payload");
      assert (CRC_POLY[0] == 1'b1)
         else $error("CRC polynomial must have a constant term");
      assert (FLIT_BYTES == 68)
         else $error("only the 68-byte flit size is supported");
   end

   logic [PL_BITS-1:0]  pl_eff;
   logic [15:0]         hdr;
   logic [15:0]         crc;
   logic [FLIT_BITS-1:0] flit_d;

   assign in_ready = !cfg_flit256 && (!out_valid || out_ready);

   for (genvar b = 0; b < PAYLOAD_BYTES; b++) begin : g_pl
      assign pl_eff[8*b +: 8] = in_payload[8*b +: 8] & {8{in_valid}};
   end

   flit_hdr_pack #(.IDLE_PID(IDLE_PID)) u_hdr (
      .idle    (!in_valid),
      .pid     (in_pid),
      .credit  (in_credit),
      .ack_cmd (in_ack_cmd),
      .seq     (in_seq),
      .hdr     (hdr)
   );

   flit_crc_gen #(
      .MSG_BYTES    (MSG_BYTES),
      .WINDOW_BYTES (WINDOW_BYTES),
      .POLY         (CRC_POLY)
   ) u_crc (
      .msg (({hdr, pl_eff})),
      .crc (crc)
   );

   assign flit_d = {hdr, pl_eff, crc};

   flit_out_stage #(.W(FLIT_BITS)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (cfg_flit256),
      .load  (in_ready),
      .d     (flit_d),
      .q     (out_flit),
      .vld   (out_valid)
   );
endmodule

// File: rtl/flit_pack_chk.sv
`timescale 1ns/1ps
module flit_pack_chk #(
   parameter int         PAYLOAD_BYTES = 64,
   parameter logic [2:0] IDLE_PID      = 3'd0
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           cfg_flit256,
   input logic                           in_valid,
   input logic                           in_ready,
   input logic [PAYLOAD_BYTES*8-1:0]     in_payload,
   input logic [2:0]                     in_pid,
   input logic                           in_credit,
   input logic [1:0]                     in_ack_cmd,
   input logic [7:0]                     in_seq,
   input logic                           out_valid,
   input logic                           out_ready,
   input logic [(PAYLOAD_BYTES+4)*8-1:0] out_flit
);
   localparam int FB = (PAYLOAD_BYTES + 4) * 8;
   localparam int PB = PAYLOAD_BYTES * 8;

   logic [15:0]   o_hdr;
   logic [PB-1:0] o_pl;
   assign o_hdr = out_flit[FB-1 -: 16];
   assign o_pl  = out_flit[FB-17 -: PB];

   assert_hdr_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> o_hdr[12:0] == {$past(in_credit), $past(in_ack_cmd), $past(in_seq), 2'b00});

   assert_pid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |=> o_hdr[15:13] == $past(in_pid));

   assert_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |=> out_valid && o_pl == $past(in_payload));

   assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> out_valid && o_pl == '0 && o_hdr[15:13] == IDLE_PID);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !cfg_flit256) |=> out_valid && $stable(out_flit));

   assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   assert_cfg_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_flit256 |-> !in_ready);

   assert_cfg_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_flit256 |=> !out_valid);
endmodule

bind flit_pack flit_pack_chk #(
   .PAYLOAD_BYTES (PAYLOAD_BYTES),
   .IDLE_PID      (IDLE_PID)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_flit256 (cfg_flit256),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .in_payload  (in_payload),
   .in_pid      (in_pid),
   .in_credit   (in_credit),
   .in_ack_cmd  (in_ack_cmd),
   .in_seq      (in_seq),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_flit    (out_flit)
);

// File: tb/test_flit_pack.sv
`timescale 1ns/1ps
module test_flit_pack;
   localparam int          CLK_PERIOD = 10;
   localparam logic [15:0] POLY       = 16'h8BB7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg = 1'b0;
   logic         iv = 1'b0;
   logic         ordy = 1'b1;
   logic [511:0] pl = '0;
   logic [2:0]   pid = '0;
   logic         cr = 1'b0;
   logic [1:0]   ak = '0;
   logic [7:0]   sq = '0;
   logic         ir;
   logic         ov;
   logic [543:0] of;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   bit           m_valid = 1'b0;
   bit           m_idle = 1'b0;
   logic [543:0] m_flit = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flit_pack i_flit_pack (
      .clk(clk), .rst_n(rst_n), .cfg_flit256(cfg),
      .in_valid(iv), .in_ready(ir), .in_payload(pl),
      .in_pid(pid), .in_credit(cr), .in_ack_cmd(ak), .in_seq(sq),
      .out_valid(ov), .out_ready(ordy), .out_flit(of)
   );

   // bit-serial CRC over a 1024-bit window, message bits first
   function automatic logic [15:0] ref_crc(input logic [527:0] m);
      logic [15:0] c = '0;
      for (int k = 0; k < 1024; k++) begin
         logic b = (k < 528) ? m[527-k] : 1'b0;
         logic fb = c[15] ^ b;
         c = {c[14:0], 1'b0};
         if (fb) c = c ^ POLY;
      end
      return c;
   endfunction

   function automatic logic [543:0] ref_flit(input logic v, input logic [511:0] p,
                                             input logic [2:0] id, input logic c,
                                             input logic [1:0] a, input logic [7:0] s);
      logic [15:0]  h = {(v ? id : 3'd0), c, a, s, 2'b00};
      logic [511:0] q = v ? p : '0;
      return {h, q, ref_crc({h, q})};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [543:0] act,
                      input logic [543:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [511:0] rnd512();
      logic [511:0] r;
      for (int w = 0; w < 16; w++) r[32*w +: 32] = $urandom;
      return r;
   endfunction

   // one clock: in_ready before the edge, model update at the edge, outputs after
   task automatic step();
      bit er;
      #1;
      er = !cfg && (!m_valid || ordy);
      chk(ir == er, "R6 in_ready", {543'd0, ir}, {543'd0, er});
      @(posedge clk);
      if (cfg) m_valid = 1'b0;
      else if (er) begin
         m_valid = 1'b1;
         m_idle  = !iv;
         m_flit  = ref_flit(iv, pl, pid, cr, ak, sq);
      end
      @(negedge clk);
      chk(ov == m_valid, "R7 out_valid", {543'd0, ov}, {543'd0, m_valid});
      if (m_valid) begin
         chk(of[543:528] == m_flit[543:528], "R2 header", of, m_flit);
         chk(of[527:16] == m_flit[527:16], m_idle ? "R5 idle payload" : "R3 payload", of, m_flit);
         chk(of[15:0] == m_flit[15:0], "R4 crc", of, m_flit);
      end
   endtask

   task automatic send(input logic [511:0] p);
      iv = 1'b1; pl = p;
      pid = 3'($urandom); cr = 1'($urandom); ak = 2'($urandom); sq = 8'($urandom);
      step();
   endtask

   task automatic idle_cycle();
      iv = 1'b0; pl = rnd512();
      pid = 3'($urandom); cr = 1'($urandom); ak = 2'($urandom); sq = 8'($urandom);
      step();
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [511:0] base;
      logic [15:0]  base_crc;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(ov == 1'b0, "R1 out_valid in reset", {543'd0, ov}, 544'd0);
      chk(ir == 1'b1, "R1 in_ready in reset", {543'd0, ir}, 544'd1);
      rst_n = 1'b1;
      #1;
      chk(ov == 1'b0, "R1 out_valid after reset", {543'd0, ov}, 544'd0);
      @(negedge clk);

      // R7, R3, R4, R2: back-to-back stream of varied patterns
      send('0);
      send('1);
      for (int i = 0; i < 64; i++) send(512'hA5 << (8*i));
      for (int i = 0; i < 40; i++) send(rnd512());

      // R5: idle flits between payloads
      for (int i = 0; i < 10; i++) begin
         idle_cycle();
         send(rnd512());
      end

      // R6: random backpressure
      for (int i = 0; i < 200; i++) begin
         ordy = 1'($urandom);
         if ($urandom % 3 == 0) idle_cycle();
         else send(rnd512());
      end
      ordy = 1'b0;
      send(rnd512());
      send(rnd512());
      send(rnd512());
      ordy = 1'b1;
      send(rnd512());

      // R8: 256-byte configuration halts the block
      cfg = 1'b1;
      send(rnd512());
      chk(ir == 1'b0, "R8 in_ready with 256-byte config", {543'd0, ir}, 544'd0);
      chk(ov == 1'b0, "R8 out_valid with 256-byte config", {543'd0, ov}, 544'd0);
      send(rnd512());
      idle_cycle();
      chk(ov == 1'b0, "R8 out_valid stays low", {543'd0, ov}, 544'd0);
      cfg = 1'b0;
      send(rnd512());
      send(rnd512());

      // R9: model-level flip detection over header plus payload (528 bits)
      for (int i = 0; i < 528; i++) begin
         logic [527:0] e = 528'd1 << i;
         logic [15:0] c = ref_crc(e);
         chk(c != 16'd0, "R9 single flip", {528'd0, c}, 544'd1);
      end
      for (int t = 0; t < 300; t++) begin
         int a = $urandom % 528;
         int b = (a + 1 + ($urandom % 527)) % 528;
         logic [527:0] e = (528'd1 << a) | (528'd1 << b);
         logic [15:0] c = ref_crc(e);
         chk(c != 16'd0, "R9 double flip", {528'd0, c}, 544'd1);
      end
      for (int t = 0; t < 300; t++) begin
         int a = $urandom % 528;
         int b = (a + 1 + ($urandom % 526)) % 528;
         int c3 = (b + 1 + ($urandom % 526)) % 528;
         logic [527:0] e;
         logic [15:0] c;
         if (c3 == a) c3 = (c3 + 1) % 528;
         if (c3 == b) c3 = (c3 + 1) % 528;
         if (c3 == a) c3 = (c3 + 1) % 528;
         e = (528'd1 << a) | (528'd1 << b) | (528'd1 << c3);
         c = ref_crc(e);
         chk(c != 16'd0, "R9 triple flip", {528'd0, c}, 544'd1);
      end

      // R9: design CRC changes for flipped payloads
      ordy = 1'b1;
      base = rnd512();
      iv = 1'b1; pl = base; pid = 3'd5; cr = 1'b1; ak = 2'd2; sq = 8'h3C;
      step();
      base_crc = of[15:0];
      for (int t = 0; t < 30; t++) begin
         logic [511:0] e = 512'd1 << ($urandom % 512);
         if (t % 3 >= 1) e = e | (512'd1 << ($urandom % 512));
         if (t % 3 == 2) e = e | (512'd1 << ($urandom % 512));
         if (e == '0) e = 512'd1;
         pl = base ^ e;
         step();
         chk(of[15:0] != base_crc, "R9 design crc after flips", {528'd0, of[15:0]},
             {528'd0, base_crc});
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule